// File: doc/BRIEF.md
# Playback Transfer Counter with Terminal-Count Interrupt

This block follows the bytes that a DMA engine moves for audio playback and compares them with a programmed sample-frame count. A format byte is decoded into a byte-per-frame shift. The shift comes from the sample encoding (8-bit, companded or 16-bit) and the channel count. The frame count is scaled by that shift into a byte limit. While playback is enabled and the format is legal, the block holds its DMA request high and accepts grants. A grant is one cycle with a byte count. The grants build up a transferred count.

When interrupts are enabled, the block shows the bytes still allowed before terminal count, and it clamps every burst to that figure. A burst that lands exactly on the limit sets the status and playback-interrupt flags, raises the IRQ and restarts the count. A clear pulse from the register side drops the flags. A reserved or unsupported encoding, or a sample-rate selection that does not exist, raises an error flag and keeps the DMA request low.

Top module: `play_xfer_ctr`

## Requirements
- R1: After reset, dma_req_o, irq_o, status_o and pi_o are all 0.
- R2: The format code is fmt_i[7:5] and stereo is fmt_i[4]. The byte limit is base_count_i shifted left by the frame shift. The shift is 0 (mono) or 1 (stereo) for code 0 (unsigned 8-bit), code 1 (mu-law) and code 3 (A-law). It is 1 (mono) or 2 (stereo) for code 2 (16-bit little-endian) and code 6 (16-bit big-endian).
- R3: With ext_mode_i low, only fmt_i[6:5] are used as the code, so 0xC0 decodes as code 2 and 0x80 as code 0.
- R4: With ext_mode_i high, codes 4, 5 and 7 set fmt_err_o, and dma_req_o stays low.
- R5: With fmt_i[0] = 0, a rate index fmt_i[3:1] of 4 or 5 sets fmt_err_o and keeps dma_req_o low. The same indices with fmt_i[0] = 1 are legal.
- R6: dma_req_o goes high one cycle after play_en_i is set with no error, and low one cycle after play_en_i clears. A fresh enable starts the transferred count at 0.
- R7: With irq_en_i high, remain_o equals limit minus transferred bytes. With irq_en_i low, remain_o is all ones.
- R8: With irq_en_i high, a granted burst is clamped to remain_o, and the clamped amount is added to the transferred count.
- R9: A burst that reaches the limit exactly sets status_o, pi_o and irq_o on the next cycle and returns the transferred count to 0.
- R10: A zero-byte grant, or a grant when remain_o is 0, changes no state.
- R11: With irq_en_i low, no grant ever raises irq_o.
- R12: irq_clear_i drops irq_o, status_o and pi_o on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_mode_i | input | 1 | Extended mode: full 3-bit format code |
| fmt_i | input | 8 | Playback format byte (code, stereo, rate index, clock table) |
| play_en_i | input | 1 | Playback enable |
| irq_en_i | input | 1 | Interrupt enable; also enables burst clamping |
| base_count_i | input | CNT_W (16) | Playback count in sample frames |
| grant_valid_i | input | 1 | DMA grant strobe for this cycle |
| grant_bytes_i | input | GRANT_W (12) | Bytes offered by the grant |
| irq_clear_i | input | 1 | Clear pulse from the register side |
| dma_req_o | output | 1 | DMA request |
| fmt_err_o | output | 1 | Illegal format or rate |
| remain_o | output | CNT_W+2 (18) | Bytes allowed before terminal count |
| status_o | output | 1 | Global interrupt status flag |
| pi_o | output | 1 | Playback interrupt flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench covers every shift case and checks the masking of the top code bit when extended mode is off. A design that ignores the mask would treat 0xC0 as big-endian, and one that drops it would flag 0x80 as reserved. It drives a burst larger than the allowance to check clamping: an unclamped counter would overshoot and never fire. It also drives a zero-length grant and a grant against a zero limit, where a careless comparison fires a spurious interrupt. Re-enabling playback after a partial transfer must restore the full allowance, or the next period ends early.

// File: rtl/pbtc_pkg.sv
package pbtc_pkg;

    typedef enum logic [2:0] {
        ENC_U8     = 3'd0,
        ENC_ULAW   = 3'd1,
        ENC_S16LE  = 3'd2,
        ENC_ALAW   = 3'd3,
        ENC_RSV4   = 3'd4,
        ENC_ADPCM  = 3'd5,
        ENC_S16BE  = 3'd6,
        ENC_RSV7   = 3'd7
    } enc_e;

    typedef struct packed {
        logic [1:0] shift;
        logic       bad_enc;
        logic       bad_rate;
    } fmt_info_t;

    typedef struct packed {
        logic status;
        logic pi;
        logic irq;
    } flags_t;

    function automatic fmt_info_t decode_fmt(input logic [7:0] f, input logic ext);
        fmt_info_t r;
        enc_e      code;
        logic      stereo;
        code   = enc_e'(ext ? f[7:5] : {1'b0, f[6:5]});
        stereo = f[4];
        r      = '0;
        case (code)
            ENC_U8, ENC_ULAW, ENC_ALAW: r.shift = {1'b0, stereo};
            ENC_S16LE, ENC_S16BE:       r.shift = stereo ? 2'd2 : 2'd1;
            default:                    r.bad_enc = 1'b1;
        endcase
        r.bad_rate = !f[0] && (f[3:1] == 3'd4 || f[3:1] == 3'd5);
        return r;
    endfunction

endpackage

// File: rtl/pbtc_fmt_decode.sv
module pbtc_fmt_decode
    import pbtc_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int XW   = CNT_W + 2
) (
    input  logic [7:0]       fmt_i,
    input  logic             ext_i,
    input  logic [CNT_W-1:0] base_i,
    output logic [XW-1:0]    limit_o,
    output logic             err_o
);
    fmt_info_t info;

    always_comb begin
        info    = decode_fmt(fmt_i, ext_i);
        limit_o = XW'(base_i) << info.shift;
        err_o   = info.bad_enc || info.bad_rate;
    end
endmodule

// File: rtl/pbtc_counter.sv
module pbtc_counter #(
    parameter int CNT_W   = 16,
    parameter int GRANT_W = 12,
    localparam int XW     = CNT_W + 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable_now,
    input  logic               running,
    input  logic               irq_en,
    input  logic [XW-1:0]      limit,
    input  logic               grant_valid,
    input  logic [GRANT_W-1:0] grant_bytes,
    output logic [XW-1:0]      remain,
    output logic               tc
);
    logic [XW-1:0] xfer_q;
    logic [XW-1:0] headroom;
    logic [XW-1:0] offered;
    logic [XW-1:0] burst;
    logic          accept;

    always_comb begin
        headroom = (xfer_q >= limit) ? '0 : (limit - xfer_q);
        remain   = irq_en ? headroom : '1;
        offered  = XW'(grant_bytes);
        burst    = (irq_en && offered > headroom) ? headroom : offered;
        accept   = running && grant_valid && (burst != '0);
        tc       = accept && irq_en && (burst == headroom);
    end

    always_ff @(posedge clk) begin
        if (rst)
            xfer_q <= '0;
        else if (!enable_now)
            xfer_q <= '0;
        else if (tc)
            xfer_q <= '0;
        else if (accept)
            xfer_q <= xfer_q + burst;
    end
endmodule

// File: rtl/pbtc_irq.sv
module pbtc_irq
    import pbtc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tc_i,
    input  logic   clr_i,
    output flags_t flags_o
);
    always_ff @(posedge clk) begin
        if (rst)
            flags_o <= '0;
        else if (tc_i)
            flags_o <= '{status: 1'b1, pi: 1'b1, irq: 1'b1};
        else if (clr_i)
            flags_o <= '0;
    end
endmodule

// File: rtl/play_xfer_ctr.sv
module play_xfer_ctr
    import pbtc_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int GRANT_W = 12,
    localparam int XW     = CNT_W + 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ext_mode_i,
    input  logic [7:0]         fmt_i,
    input  logic               play_en_i,
    input  logic               irq_en_i,
    input  logic [CNT_W-1:0]   base_count_i,
    input  logic               grant_valid_i,
    input  logic [GRANT_W-1:0] grant_bytes_i,
    input  logic               irq_clear_i,
    output logic               dma_req_o,
    output logic               fmt_err_o,
    output logic [XW-1:0]      remain_o,
    output logic               status_o,
    output logic               pi_o,
    output logic               irq_o
);
    logic [XW-1:0] limit;
    logic          err;
    logic          enable_now;
    logic          run_q;
    logic          tc;
    flags_t        flags;

    pbtc_fmt_decode #(.CNT_W(CNT_W)) u_dec (
        .fmt_i  (fmt_i),
        .ext_i  (ext_mode_i),
        .base_i (base_count_i),
        .limit_o(limit),
        .err_o  (err)
    );

    assign enable_now = play_en_i && !err;

    always_ff @(posedge clk) begin
        if (rst) run_q <= 1'b0;
        else     run_q <= enable_now;
    end

    pbtc_counter #(.CNT_W(CNT_W), .GRANT_W(GRANT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .enable_now (enable_now),
        .running    (run_q),
        .irq_en     (irq_en_i),
        .limit      (limit),
        .grant_valid(grant_valid_i),
        .grant_bytes(grant_bytes_i),
        .remain     (remain_o),
        .tc         (tc)
    );

    pbtc_irq u_irq (
        .clk    (clk),
        .rst    (rst),
        .tc_i   (tc),
        .clr_i  (irq_clear_i),
        .flags_o(flags)
    );

    assign dma_req_o = run_q;
    assign fmt_err_o = err;
    assign status_o  = flags.status;
    assign pi_o      = flags.pi;
    assign irq_o     = flags.irq;
endmodule

// File: rtl/play_xfer_ctr_chk.sv
module play_xfer_ctr_chk (
    input logic clk,
    input logic rst,
    input logic play_en_i,
    input logic irq_en_i,
    input logic grant_valid_i,
    input logic irq_clear_i,
    input logic fmt_err_o,
    input logic dma_req_o,
    input logic status_o,
    input logic pi_o,
    input logic irq_o
);
    // R4 R5
    err_blocks_req_chk: assert property (@(posedge clk) disable iff (rst)
        fmt_err_o |=> !dma_req_o);

    // R6
    disable_drops_req_chk: assert property (@(posedge clk) disable iff (rst)
        !play_en_i |=> !dma_req_o);

    // R12
    clear_drops_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_clear_i && !grant_valid_i) |=> (!irq_o && !status_o && !pi_o));

    // R11
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past(irq_en_i));

    // R9
    flags_together_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> (status_o && pi_o));
endmodule

bind play_xfer_ctr play_xfer_ctr_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .play_en_i    (play_en_i),
    .irq_en_i     (irq_en_i),
    .grant_valid_i(grant_valid_i),
    .irq_clear_i  (irq_clear_i),
    .fmt_err_o    (fmt_err_o),
    .dma_req_o    (dma_req_o),
    .status_o     (status_o),
    .pi_o         (pi_o),
    .irq_o        (irq_o)
);

// File: tb/play_xfer_ctr_test.sv
module play_xfer_ctr_test;
    localparam int PERIOD = 10;
    localparam int XW = 18;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_mode_i = 1'b0;
    logic [7:0]  fmt_i = 8'h00;
    logic        play_en_i = 1'b0;
    logic        irq_en_i = 1'b0;
    logic [15:0] base_count_i = 16'd0;
    logic        grant_valid_i = 1'b0;
    logic [11:0] grant_bytes_i = 12'd0;
    logic        irq_clear_i = 1'b0;
    logic        dma_req_o, fmt_err_o, status_o, pi_o, irq_o;
    logic [XW-1:0] remain_o;

    int checks = 0;
    int fails  = 0;

    always #(PERIOD/2) clk = ~clk;

    play_xfer_ctr uut (.*);

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic start(input logic [7:0] f, input logic ext, input int base, input logic ien);
        play_en_i = 1'b0;
        step();
        fmt_i = f; ext_mode_i = ext; base_count_i = 16'(base); irq_en_i = ien;
        play_en_i = 1'b1;
        step();
    endtask

    task automatic grant(input int n);
        grant_valid_i = 1'b1; grant_bytes_i = 12'(n);
        step();
        grant_valid_i = 1'b0; grant_bytes_i = '0;
    endtask

    task automatic clear_irq();
        irq_clear_i = 1'b1;
        step();
        irq_clear_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 dma_req", dma_req_o, 0);
        chk("R1 irq", irq_o, 0);
        chk("R1 status", status_o, 0);
        chk("R1 pi", pi_o, 0);
    endtask

    task automatic t_shift();
        start(8'h00, 1'b0, 16, 1'b1); chk("R2 u8 mono", remain_o, 16);
        start(8'h10, 1'b0, 16, 1'b1); chk("R2 u8 stereo", remain_o, 32);
        start(8'h30, 1'b0, 16, 1'b1); chk("R2 ulaw stereo", remain_o, 32);
        start(8'h40, 1'b0, 16, 1'b1); chk("R2 s16 mono", remain_o, 32);
        start(8'h50, 1'b0, 16, 1'b1); chk("R2 s16 stereo", remain_o, 64);
        start(8'hD0, 1'b1, 16, 1'b1); chk("R2 s16be stereo", remain_o, 64);
        chk("R6 req up", dma_req_o, 1);
    endtask

    task automatic t_mask();
        start(8'hC0, 1'b0, 16, 1'b1);
        chk("R3 0xC0 as code 2", remain_o, 32);
        chk("R3 no err", fmt_err_o, 0);
        start(8'h80, 1'b0, 16, 1'b1);
        chk("R3 0x80 as code 0", remain_o, 16);
        chk("R3 req", dma_req_o, 1);
    endtask

    task automatic t_bad_enc();
        start(8'hA0, 1'b1, 16, 1'b1);
        chk("R4 code5 err", fmt_err_o, 1);
        chk("R4 code5 no req", dma_req_o, 0);
        start(8'h80, 1'b1, 16, 1'b1);
        chk("R4 code4 err", fmt_err_o, 1);
        start(8'hE0, 1'b1, 16, 1'b1);
        chk("R4 code7 err", fmt_err_o, 1);
        chk("R4 code7 no req", dma_req_o, 0);
    endtask

    task automatic t_rate();
        start(8'h08, 1'b0, 16, 1'b1);
        chk("R5 idx4 err", fmt_err_o, 1);
        chk("R5 idx4 no req", dma_req_o, 0);
        start(8'h0A, 1'b0, 16, 1'b1);
        chk("R5 idx5 err", fmt_err_o, 1);
        start(8'h09, 1'b0, 16, 1'b1);
        chk("R5 alt table ok", fmt_err_o, 0);
        chk("R5 alt table req", dma_req_o, 1);
    endtask

    task automatic t_burst();
        start(8'h00, 1'b0, 16, 1'b1);
        grant(5);
        chk("R7 remain after 5", remain_o, 11);
        chk("R8 no irq yet", irq_o, 0);
        grant(20);
        chk("R9 irq", irq_o, 1);
        chk("R9 status", status_o, 1);
        chk("R9 pi", pi_o, 1);
        chk("R9 count restarted", remain_o, 16);
        clear_irq();
        chk("R12 irq", irq_o, 0);
        chk("R12 status", status_o, 0);
        chk("R12 pi", pi_o, 0);
        grant(10); grant(6);
        chk("R9 exact hit", irq_o, 1);
        clear_irq();
    endtask

    task automatic t_zero();
        start(8'h00, 1'b0, 16, 1'b1);
        grant(3);
        grant(0);
        chk("R10 zero grant remain", remain_o, 13);
        chk("R10 zero grant irq", irq_o, 0);
        start(8'h00, 1'b0, 0, 1'b1);
        chk("R10 zero limit remain", remain_o, 0);
        grant(3);
        chk("R10 zero limit irq", irq_o, 0);
        chk("R10 zero limit remain after", remain_o, 0);
    endtask

    task automatic t_no_ien();
        start(8'h00, 1'b0, 16, 1'b0);
        chk("R7 all ones", remain_o, (1 << XW) - 1);
        grant(16); grant(100);
        chk("R11 no irq", irq_o, 0);
        chk("R11 no pi", pi_o, 0);
    endtask

    task automatic t_restart();
        start(8'h00, 1'b0, 16, 1'b1);
        grant(7);
        chk("R6 partial", remain_o, 9);
        play_en_i = 1'b0;
        step();
        chk("R6 req down", dma_req_o, 0);
        grant(4);
        play_en_i = 1'b1;
        step();
        chk("R6 restart full", remain_o, 16);
        chk("R6 req back", dma_req_o, 1);
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        step(); step();
        rst = 1'b0;
        step();
        t_reset();
        t_shift();
        t_mask();
        t_bad_enc();
        t_rate();
        t_burst();
        t_zero();
        t_no_ien();
        t_restart();
        finish_up();
    end
endmodule